// File: doc/BRIEF.md
# Interrupt-Driven Transmit Sequencer

This block runs on the host side of a packet radio transceiver. It moves one packet from a byte source into the transceiver's transmit buffer. The only pacing it uses is the transceiver's byte-done interrupt, so it never counts bit times. When a frame begins, the sequencer raises the buffer enable. One cycle later it raises the transmitter enable. After that, each rising edge of the interrupt causes exactly one write into the transmit buffer.

Once the last real byte has gone out, the sequencer writes one trailer byte of fixed value, whose content is discarded. The interrupt that follows shows that every payload byte has left the radio. On that interrupt the sequencer drops the transmitter enable, then drops the buffer enable, and then emits a one-cycle done pulse. The sequence depends only on interrupt events, so any change in the on-air data rate leaves its behaviour unchanged.

Sometimes the source has nothing to offer when an interrupt arrives mid-frame. In that case the sequencer writes the trailer byte at once, ends the frame early and raises an error flag.

Top module: `tx_seq_ctrl`

## Requirements
- R1: While rst_ni is low and just after it is released, wr_o, reg_en_o, tx_en_o, done_o, err_o and src_ready_o are all low.
- R2: In the idle state, src_valid_i high starts a frame. reg_en_o rises on the next clock edge and tx_en_o rises exactly one edge later. err_o is cleared on the same edge on which reg_en_o rises.
- R3: After tx_en_o is high, each low-to-high transition of irq_i produces exactly one write, however long irq_i stays high. If a byte is offered, src_ready_o is high during the first cycle in which irq_i is high. wr_o is then a one-cycle pulse on the next edge, and wr_data_o carries the byte that was offered.
- R4: The irq_i rising edge after the byte marked by src_last_i writes the trailer byte DUMMY_BYTE, which is 8'h00 by default.
- R5: The irq_i rising edge after the trailer write clears tx_en_o on the next edge, with no write and with reg_en_o still high.
- R6: reg_en_o falls one edge after tx_en_o falls. done_o is high for exactly that one cycle, in which both enables are low.
- R7: If src_valid_i is low at an irq_i rising edge in the middle of a frame, the trailer byte is written at once and err_o rises on the same edge as that write. The next irq_i rising edge shuts the frame down as in R5 and R6. err_o stays high until the next frame starts.
- R8: irq_i edges while idle cause no write and raise no enable.
- R9: The sequence of written bytes and enable changes does not depend on how many cycles separate interrupts or how long irq_i is held.
- R10: wr_o is high only while both reg_en_o and tx_en_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_data_i | input | 8 | Byte offered by the packet source |
| src_valid_i | input | 1 | Source has a byte |
| src_last_i | input | 1 | Offered byte is the last of the packet |
| src_ready_o | output | 1 | Offered byte is taken this cycle |
| irq_i | input | 1 | Byte-done interrupt from the transceiver, edge sensitive |
| reg_en_o | output | 1 | Transmit buffer enable |
| tx_en_o | output | 1 | Transmitter enable |
| wr_o | output | 1 | One-cycle write strobe to the transmit buffer |
| wr_data_o | output | 8 | Byte to write |
| done_o | output | 1 | One-cycle pulse once the frame is fully shut down |
| err_o | output | 1 | Last frame ended because the source ran dry |

## Verification
Full frames of one and five bytes check that the feed stops exactly at the last byte and that the trailer and shutdown interrupts follow in the right order. The same five-byte packet is then sent with short, narrow interrupts and again with long, widely spaced ones. This shows that neither the interrupt width nor the data rate changes what is written. A packet whose source offers only two of four bytes covers the starvation path and the error flag, and the next frame shows that the flag clears. Interrupts sent while idle confirm that nothing happens outside a frame.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REG_ON,
    ST_FEED,
    ST_TRAIL,
    ST_DRAIN,
    ST_TX_OFF
  } seq_state_e;
endpackage

// File: rtl/tx_irq_edge.sv
module tx_irq_edge #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  output logic evt_o
);
  logic irq_s;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign irq_s = irq_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else if (SYNC_STAGES == 1) sync_q <= irq_i;
        else sync_q <= {sync_q[SYNC_STAGES-2:0], irq_i};
      end
      assign irq_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= irq_s;
  end

  assign evt_o = irq_s & ~irq_q;
endmodule

// File: rtl/tx_wr_stage.sv
module tx_wr_stage #(
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] DUMMY_BYTE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              dummy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_o      <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_o <= req_i;
      if (req_i) wr_data_o <= dummy_i ? DUMMY_BYTE : data_i;
    end
  end
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic src_valid_i,
  input  logic src_last_i,
  output logic src_ready_o,
  output logic wr_req_o,
  output logic wr_dummy_o,
  output logic reg_en_o,
  output logic tx_en_o,
  output logic done_o,
  output logic err_o
);
  seq_state_e state_q, state_d;
  logic reg_en_d, tx_en_d, done_d, err_d;

  always_comb begin
    state_d     = state_q;
    reg_en_d    = reg_en_o;
    tx_en_d     = tx_en_o;
    err_d       = err_o;
    done_d      = 1'b0;
    src_ready_o = 1'b0;
    wr_req_o    = 1'b0;
    wr_dummy_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (src_valid_i) begin
        reg_en_d = 1'b1;
        err_d    = 1'b0;
        state_d  = ST_REG_ON;
      end
      ST_REG_ON: begin
        tx_en_d = 1'b1;
        state_d = ST_FEED;
      end
      ST_FEED: if (evt_i) begin
        wr_req_o = 1'b1;
        if (src_valid_i) begin
          src_ready_o = 1'b1;
          if (src_last_i) state_d = ST_TRAIL;
        end else begin
          // source ran dry: close the frame with the trailer now
          wr_dummy_o = 1'b1;
          err_d      = 1'b1;
          state_d    = ST_DRAIN;
        end
      end
      ST_TRAIL: if (evt_i) begin
        wr_req_o   = 1'b1;
        wr_dummy_o = 1'b1;
        state_d    = ST_DRAIN;
      end
      ST_DRAIN: if (evt_i) begin
        tx_en_d = 1'b0;
        state_d = ST_TX_OFF;
      end
      ST_TX_OFF: begin
        reg_en_d = 1'b0;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      reg_en_o <= 1'b0;
      tx_en_o  <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      state_q  <= state_d;
      reg_en_o <= reg_en_d;
      tx_en_o  <= tx_en_d;
      done_o   <= done_d;
      err_o    <= err_d;
    end
  end
endmodule

// File: rtl/tx_seq_ctrl.sv
module tx_seq_ctrl #(
  parameter int                DATA_W      = 8,
  parameter logic [DATA_W-1:0] DUMMY_BYTE  = '0,
  parameter int                SYNC_STAGES = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i,
  input  logic              src_last_i,
  output logic              src_ready_o,
  input  logic              irq_i,
  output logic              reg_en_o,
  output logic              tx_en_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              err_o
);
  logic evt, wr_req, wr_dummy;

  tx_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .evt_o (evt)
  );

  tx_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .src_valid_i(src_valid_i),
    .src_last_i (src_last_i),
    .src_ready_o(src_ready_o),
    .wr_req_o   (wr_req),
    .wr_dummy_o (wr_dummy),
    .reg_en_o   (reg_en_o),
    .tx_en_o    (tx_en_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  tx_wr_stage #(.DATA_W(DATA_W), .DUMMY_BYTE(DUMMY_BYTE)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (wr_req),
    .dummy_i  (wr_dummy),
    .data_i   (src_data_i),
    .wr_o     (wr_o),
    .wr_data_o(wr_data_o)
  );
endmodule

// File: rtl/tx_seq_chk.sv
module tx_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic src_valid_i,
  input logic src_ready_o,
  input logic reg_en_o,
  input logic tx_en_o,
  input logic wr_o,
  input logic done_o,
  input logic err_o
);
  a_r2_reg_before_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> reg_en_o && $past(reg_en_o));

  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  a_r3_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> src_valid_i);

  a_r6_reg_after_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_en_o) |-> !tx_en_o && !$past(tx_en_o));

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !reg_en_o && !tx_en_o);

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_err_with_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> wr_o);

  a_r10_write_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> reg_en_o && tx_en_o);
endmodule

bind tx_seq_ctrl tx_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_valid_i(src_valid_i),
  .src_ready_o(src_ready_o),
  .reg_en_o   (reg_en_o),
  .tx_en_o    (tx_en_o),
  .wr_o       (wr_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sim_tx_seq_ctrl.sv
`timescale 1ns/1ps
module sim_tx_seq_ctrl;
  localparam logic [7:0] DUMMY = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq = 1'b0;
  logic [7:0] src_data;
  logic src_valid, src_last, src_ready;
  logic reg_en, tx_en, wr, done, err;
  logic [7:0] wr_data;

  logic [7:0] pkt [16];
  int n_bytes = 0, n_avail = 0, idx = 0;
  int total = 0, passed = 0, wr_seen = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  always_comb begin
    src_valid = idx < n_avail;
    src_last  = idx == n_bytes - 1;
    src_data  = pkt[idx[3:0]];
  end

  tx_seq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_data_i(src_data), .src_valid_i(src_valid),
    .src_last_i(src_last), .src_ready_o(src_ready), .irq_i(irq), .reg_en_o(reg_en),
    .tx_en_o(tx_en), .wr_o(wr), .wr_data_o(wr_data), .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr) begin
      wr_seen++;
      if (exp_q.size() == 0) chk(1'b0, "R8", "unexpected write", int'(wr_data), -1);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        chk(wr_data == e, "R3", "written byte", int'(wr_data), int'(e));
      end
    end
  end

  task automatic fire_irq(input int hold, input int gap);
    bit took;
    @(negedge clk);
    irq = 1'b1;
    #1;
    took = src_ready;
    @(negedge clk);
    if (took) idx++;
    repeat (hold - 1) @(negedge clk);
    irq = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic run_frame(input int nb, input int na, input int hold, input int gap, input int base);
    int k, w0;
    k = (na < nb) ? na : nb;
    for (int i = 0; i < 16; i++) pkt[i] = 8'(base + 3 * i + 1);
    for (int i = 0; i < k; i++) exp_q.push_back(pkt[i]);
    exp_q.push_back(DUMMY);
    w0 = wr_seen;
    @(negedge clk);
    n_bytes = nb; n_avail = na; idx = 0;
    @(negedge clk);
    chk(reg_en && !tx_en, "R2", "reg_en first", {reg_en, tx_en}, 2);
    chk(!err, "R7", "err cleared at frame start", err, 0);
    @(negedge clk);
    chk(reg_en && tx_en, "R2", "tx_en one cycle later", {reg_en, tx_en}, 3);
    for (int i = 0; i < k; i++) fire_irq(hold, gap);
    fire_irq(hold, gap);
    chk(exp_q.size() == 0, "R4", "trailer written", exp_q.size(), 0);
    chk(err == (na < nb), "R7", "error flag", err, int'(na < nb));
    chk(wr_seen - w0 == k + 1, "R9", "write count", wr_seen - w0, k + 1);
    @(negedge clk);
    irq = 1'b1;
    @(negedge clk);
    chk(!tx_en && reg_en && !done, "R5", "tx_en off first", {reg_en, tx_en, done}, 4);
    @(negedge clk);
    chk(!tx_en && !reg_en && done, "R6", "reg_en off with done", {reg_en, tx_en, done}, 1);
    irq = 1'b0;
    @(negedge clk);
    chk(!done && !reg_en, "R6", "done one cycle", {reg_en, done}, 0);
    chk(wr_seen - w0 == k + 1, "R5", "no write at shutdown", wr_seen - w0, k + 1);
    chk(err == (na < nb), "R7", "error flag held", err, int'(na < nb));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr && !reg_en && !tx_en && !done && !err && !src_ready, "R1", "reset outputs",
        {wr, reg_en, tx_en, done, err, src_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr && !reg_en && !tx_en && !done && !err, "R1", "after reset",
        {wr, reg_en, tx_en, done, err}, 0);
    // R8: interrupts while idle
    fire_irq(1, 2);
    fire_irq(4, 2);
    chk(!reg_en && !tx_en && wr_seen == 0, "R8", "idle irq ignored", {reg_en, tx_en, wr_seen[1:0]}, 0);
    run_frame(1, 1, 1, 2, 8'h10);    // single byte frame (R4)
    run_frame(5, 5, 1, 1, 8'h20);    // tight interrupts (R3, R9)
    run_frame(5, 5, 6, 25, 8'h20);   // long held, slow interrupts (R3, R9)
    run_frame(4, 2, 2, 3, 8'h40);    // source starves (R7)
    run_frame(3, 3, 2, 3, 8'h60);    // error clears on next frame (R7)
    chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule